// File: doc/BRIEF.md
# Ripple-Through Register Queue

A small first-in first-out queue made of a chain of storage stages. It holds `DEPTH` words of `DATA_W` bits (four of four by default). Each stage carries one occupancy flag. A word written at the head of the chain moves toward the tail by one stage per clock, as long as the stage ahead is empty. There are no read or write pointers. The time a word takes to cross depends on how many words are already waiting: in an empty queue a word reaches the tail after `DEPTH` clocks, and in a busier one it stops behind the last occupied stage.

The writer uses a handshake that the writer starts. It raises `put_req` with a word on `put_data`, and the word is taken on a clock edge where `put_rdy` is high. The reader uses a handshake that the queue starts. `take_rdy` tells the reader that `take_data` holds the oldest word, and `take_req` removes that word. Everything runs on one clock. A stage loads through an enable and does not use a clock of its own. A synchronous `clear` empties every stage.

Each stage is a two-state machine. Its states are `ST_VACANT` and `ST_OCCUPIED`. It has three transitions:
- FILL (`ST_VACANT` to `ST_OCCUPIED`) loads the word offered by the stage behind it, or by the writer at the head.
- DRAIN (`ST_OCCUPIED` to `ST_VACANT`) runs when the word moves on to the stage ahead, or leaves through `take_req` at the tail.
- CLEAR forces any state to `ST_VACANT`.

Top module: `ripple_fifo`

## Requirements
- R1: One clock edge with `clear` high leaves every stage empty: `put_rdy` is 1 and `take_rdy` is 0 afterwards.
- R2: `put_rdy` is 1 exactly when the head stage is empty. A `put_req` on an edge where `put_rdy` is 1 stores `put_data` in the head stage, and `put_rdy` reads 0 after that edge.
- R3: A `put_req` on an edge where `put_rdy` is 0 is ignored. The offered word never appears at `take_data`.
- R4: On every edge, each occupied stage whose next stage is empty moves its word into that next stage. In an otherwise empty queue, a word accepted on edge k is presented on `take_rdy`/`take_data` after edge k+`DEPTH`-1 (four edges after acceptance at the default depth, counting the accepting edge as the first).
- R5: All stage moves are decided from the flags as they stood before the edge. A stage emptied on an edge can be refilled no earlier than the following edge.
- R6: `take_rdy` equals the tail stage's flag, and `take_data` is its word. While `take_req` is low, both hold steady. A `take_req` while `take_rdy` is 1 empties the tail stage on that edge.
- R7: A `take_req` while `take_rdy` is 0 changes nothing. A word already in flight still arrives with the latency of R4.
- R8: Words leave in the order they were accepted.
- R9: `clear` takes priority over `put_req`, `take_req` and every stage move on the same edge.
- R10: The queue holds `DEPTH` words. With all stages occupied, `put_rdy` stays 0 until a word is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clear | input | 1 | Synchronous active-high master clear |
| put_req | input | 1 | Writer offers a word |
| put_data | input | DATA_W | Word offered by the writer |
| put_rdy | output | 1 | Head stage empty, a word can be accepted |
| take_rdy | output | 1 | Tail stage holds the oldest word |
| take_req | input | 1 | Reader removes the tail word |
| take_data | output | DATA_W | Word in the tail stage |

## Verification
The assertions check the following on every cycle:
- the clear outcome;
- that an accepted word closes the head;
- that an occupied stage with an empty successor hands its word forward, data included;
- that no stage is filled while occupied or drained while empty;
- that a tail word holds until taken and that the tail is empty right after a take.

Some behaviour only the bench scenarios can show. This covers the exact crossing latency and order across whole sequences of words. It also covers refused writes to a full queue, which must never surface. Finally, it covers take requests on an empty tail, which must leave the words in flight undisturbed.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
    typedef enum logic {
        ST_VACANT   = 1'b0,
        ST_OCCUPIED = 1'b1
    } stage_state_t;
endpackage

// File: rtl/rfifo_stage.sv
module rfifo_stage
    import rfifo_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              fill_i,
    input  logic              drain_i,
    input  logic [DATA_W-1:0] d_i,
    output logic              full_o,
    output logic [DATA_W-1:0] q_o
);
    stage_state_t state_q, state_d;
    logic [DATA_W-1:0] word_q;

    // state register
    always_ff @(posedge clk) begin
        if (clear) state_q <= ST_VACANT;
        else       state_q <= state_d;
    end

    // next state: FILL and DRAIN transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_VACANT:   if (fill_i)  state_d = ST_OCCUPIED;
            ST_OCCUPIED: if (drain_i) state_d = ST_VACANT;
            default:     state_d = ST_VACANT;
        endcase
    end

    // word register, loaded only on the FILL transition
    always_ff @(posedge clk) begin
        if (clear)                               word_q <= '0;
        else if (state_q == ST_VACANT && fill_i) word_q <= d_i;
    end

    // outputs
    always_comb begin
        full_o = (state_q == ST_OCCUPIED);
        q_o    = word_q;
    end

    // R5: neighbour logic never offers a word to an occupied stage
    p_fill_vacant_r5: assert property (@(posedge clk) disable iff (clear)
        fill_i |-> !full_o);

    // R6: a stage is only drained while it holds a word
    p_drain_held_r6: assert property (@(posedge clk) disable iff (clear)
        drain_i |-> full_o);
endmodule

// File: rtl/rfifo_chain.sv
module rfifo_chain #(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              head_push,
    input  logic [DATA_W-1:0] head_data,
    input  logic              tail_pop,
    output logic              head_full,
    output logic              tail_full,
    output logic [DATA_W-1:0] tail_data
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0]  flag;
    logic [DEPTH-1:0]  fill;
    logic [DEPTH-1:0]  drain;
    logic [DATA_W-1:0] word [DEPTH];
    logic [DATA_W-1:0] feed [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign fill[i] = head_push & ~flag[i];
                assign feed[i] = head_data;
            end else begin : g_body
                assign fill[i] = flag[i-1] & ~flag[i];
                assign feed[i] = word[i-1];
            end

            if (i == LAST) begin : g_tail
                assign drain[i] = tail_pop & flag[i];
            end else begin : g_move
                assign drain[i] = flag[i] & ~flag[i+1];

                // R4: an occupied stage with an empty successor hands its word forward
                p_advance_r4: assert property (@(posedge clk) disable iff (clear)
                    (flag[i] && !flag[i+1]) |=> (flag[i+1] && word[i+1] == $past(word[i])));
            end

            rfifo_stage #(.DATA_W(DATA_W)) u_stage (
                .clk     (clk),
                .clear   (clear),
                .fill_i  (fill[i]),
                .drain_i (drain[i]),
                .d_i     (feed[i]),
                .full_o  (flag[i]),
                .q_o     (word[i])
            );
        end
    endgenerate

    assign head_full = flag[0];
    assign tail_full = flag[LAST];
    assign tail_data = word[LAST];
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              put_req,
    input  logic [DATA_W-1:0] put_data,
    output logic              put_rdy,
    output logic              take_rdy,
    input  logic              take_req,
    output logic [DATA_W-1:0] take_data
);
    logic head_full;
    logic tail_full;

    rfifo_chain #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chain (
        .clk       (clk),
        .clear     (clear),
        .head_push (put_req),
        .head_data (put_data),
        .tail_pop  (take_req),
        .head_full (head_full),
        .tail_full (tail_full),
        .tail_data (take_data)
    );

    assign put_rdy  = ~head_full;
    assign take_rdy = tail_full;

    // R1 / R9: clear empties the queue whatever else is requested
    p_clear_r1: assert property (@(posedge clk)
        clear |=> (put_rdy && !take_rdy));

    // R2: an accepted word occupies the head stage
    p_accept_r2: assert property (@(posedge clk) disable iff (clear)
        (put_req && put_rdy) |=> !put_rdy);

    // R6: the tail word holds until taken
    p_hold_r6: assert property (@(posedge clk) disable iff (clear)
        (take_rdy && !take_req) |=> (take_rdy && $stable(take_data)));

    // R5: a tail emptied by a take cannot be refilled on the same edge
    p_take_r5: assert property (@(posedge clk) disable iff (clear)
        (take_rdy && take_req) |=> !take_rdy);
endmodule

// File: tb/tb_ripple_fifo.sv
module tb_ripple_fifo;
    localparam int W = 4;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         clear = 1'b1;
    logic         put_req = 1'b0;
    logic [W-1:0] put_data = '0;
    logic         put_rdy, take_rdy, take_req;
    logic [W-1:0] take_data;

    logic         mon_en  = 1'b0;
    logic         mon_del = 1'b0;
    logic         man_del = 1'b0;
    logic [15:0]  lfsr = 16'hACE1;
    int           tests = 0;
    int           fails = 0;
    int           cyc   = 0;
    logic [W-1:0] exp_q [$];

    assign take_req = mon_en ? mon_del : man_del;

    ripple_fifo #(.DATA_W(W), .DEPTH(D)) dut (
        .clk(clk), .clear(clear), .put_req(put_req), .put_data(put_data),
        .put_rdy(put_rdy), .take_rdy(take_rdy), .take_req(take_req),
        .take_data(take_data)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // monitor: pops the scoreboard as words leave (R8)
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mon_del = 1'b0;
        if (mon_en && take_rdy && lfsr[0]) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected word", take_data, -1);
            end else begin
                chk(take_data == exp_q[0], "R8 order", take_data, exp_q[0]);
                void'(exp_q.pop_front());
            end
            mon_del = 1'b1;
        end
    end

    // driver: called at a negedge, returns at the negedge after acceptance
    task automatic push_word(input logic [W-1:0] w);
        while (!put_rdy) @(negedge clk);
        put_req  = 1'b1;
        put_data = w;
        exp_q.push_back(w);
        @(negedge clk);
        put_req = 1'b0;
    endtask

    task automatic wait_empty();
        for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(negedge clk);
        chk(exp_q.size() == 0, "R8 drain complete", exp_q.size(), 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        clear = 1'b0;
        chk(put_rdy == 1'b1, "R1 put_rdy after clear", put_rdy, 1);
        chk(take_rdy == 1'b0, "R1 take_rdy after clear", take_rdy, 0);

        // R7: take on an empty tail changes nothing
        man_del = 1'b1;
        repeat (2) @(negedge clk);
        chk(take_rdy == 1'b0 && put_rdy == 1'b1, "R7 take on empty", take_rdy, 0);
        man_del = 1'b0;

        // R2/R4 latency from an empty queue; R7 take while in flight
        push_word(4'h9);
        chk(put_rdy == 1'b0, "R2 head occupied", put_rdy, 0);
        man_del = 1'b1;
        @(negedge clk);
        chk(take_rdy == 1'b0, "R7 edge 2", take_rdy, 0);
        chk(put_rdy == 1'b1, "R4 head freed", put_rdy, 1);
        man_del = 1'b0;
        @(negedge clk);
        chk(take_rdy == 1'b0, "R4 edge 3", take_rdy, 0);
        @(negedge clk);
        chk(take_rdy == 1'b1, "R4 edge 4", take_rdy, 1);
        chk(take_data == 4'h9, "R4 data", take_data, 9);
        repeat (2) @(negedge clk);
        chk(take_rdy == 1'b1 && take_data == 4'h9, "R6 hold", take_data, 9);
        mon_en = 1'b1;
        wait_empty();
        mon_en = 1'b0;
        @(negedge clk);

        // R10 full, R3 refused word
        push_word(4'h1); push_word(4'h2); push_word(4'h3); push_word(4'h4);
        repeat (3) @(negedge clk);
        chk(put_rdy == 1'b0, "R10 full", put_rdy, 0);
        put_req = 1'b1; put_data = 4'hE;
        repeat (3) @(negedge clk);
        put_req = 1'b0;
        chk(take_rdy == 1'b1 && take_data == 4'h1, "R8 oldest at tail", take_data, 1);
        void'(exp_q.pop_front());
        man_del = 1'b1;
        @(negedge clk);
        man_del = 1'b0;
        chk(take_rdy == 1'b0, "R5 tail not refilled same edge", take_rdy, 0);
        @(negedge clk);
        chk(take_rdy == 1'b1 && take_data == 4'h2, "R6 next word", take_data, 2);
        mon_en = 1'b1;
        wait_empty();
        repeat (8) @(negedge clk);
        chk(take_rdy == 1'b0, "R3 refused word absent", take_rdy, 0);
        mon_en = 1'b0;

        // R9: clear beats put and take
        push_word(4'h5); push_word(4'h6); push_word(4'h7); push_word(4'h8);
        repeat (3) @(negedge clk);
        clear = 1'b1; put_req = 1'b1; put_data = 4'hA; man_del = 1'b1;
        @(negedge clk);
        clear = 1'b0; put_req = 1'b0; man_del = 1'b0;
        exp_q.delete();
        chk(put_rdy == 1'b1 && take_rdy == 1'b0, "R9 clear wins", take_rdy, 0);
        repeat (6) @(negedge clk);
        chk(take_rdy == 1'b0, "R9 nothing survives", take_rdy, 0);

        // streaming with irregular reader (R8)
        mon_en = 1'b1;
        for (int i = 0; i < 24; i++) begin
            push_word(W'((i * 7 + 3) % 16));
            repeat (i % 3) @(negedge clk);
        end
        wait_empty();
        mon_en = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule